// File: doc/BRIEF.md
# Oscillator Frequency Classifier

This block works out which of six standard system oscillator frequencies drives its fast clock. After a start request it counts fast-clock cycles across a window bounded by ticks of a slow 32 kHz reference. It scales that count by an optional input pre-divider and sorts the result into fixed bins. Each bin gives a frequency class, a 3-bit input-select code, a divide-by-two enable for the input clock and a parameter-table index.

The reference arrives as a level. It is brought into the fast domain through a two-flop synchroniser, and its rising edges are detected there. A measurement first lets a lead-in number of reference ticks go by, so that the window opens exactly on a tick. It then latches the free-running cycle count and closes the window a fixed number of ticks later. The results are registered, and a one-cycle done pulse marks them.

Top module: `osc_freq_classifier`

## Requirements
- R1: After reset `done_o` is 0, `class_o` is 0 (12 MHz), `sel_o` is 0, `div2_o` is 0 and `idx_o` is 0.
- R2: An accepted start first waits for LEAD_TICKS reference rising edges (default 20), then measures over WIN_TICKS further rising edges (default 20). With ticks T cycles apart, the elapsed count is WIN_TICKS*T. `done_o` follows the last window tick before the next reference rising edge.
- R3: The elapsed count is the end count minus the start count of a CNT_W-bit counter, modulo 2^CNT_W, so it stays correct when the counter wraps inside a measurement.
- R4: `prediv_i` is sampled when a start is accepted. When it is 1 the elapsed count is doubled before classification; when it is 0 the count is used unchanged.
- R5: Classification uses strict greater-than comparisons, tested from the highest bin down: above TH_38M4 (19000) gives class 5 (38.4 MHz), above TH_26M (15200) class 4 (26 MHz), above TH_24M (13000) class 3 (24 MHz), above TH_19M2 (9000) class 2 (19.2 MHz), above TH_13M (7600) class 1 (13 MHz), and anything else class 0 (12 MHz).
- R6: `sel_o` is 4 for class 5, 3 for class 4, 2 for class 2 and 1 for class 1. It is 0 for class 0 and for class 3.
- R7: `div2_o` is 1 exactly when `sel_o` > 2. In that case `idx_o` = `sel_o` >> 1; otherwise `idx_o` = `sel_o`.
- R8: `done_o` is high for exactly one cycle per measurement. `class_o`, `sel_o`, `div2_o` and `idx_o` change only in that cycle and hold their values between measurements.
- R9: A start request that arrives while a measurement is in progress is ignored. In particular, its `prediv_i` value does not affect the result.
- R10: A reference tick is counted once per rising edge of the synchronised reference, however long the reference stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock being measured |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Slow reference level, asynchronous to clk_i |
| start_i | input | 1 | Measurement request, taken only when idle |
| prediv_i | input | 1 | Input pre-divider by two is active |
| done_o | output | 1 | One-cycle pulse when new results are valid |
| class_o | output | 3 | Frequency class code (0..5, see R5) |
| sel_o | output | 3 | Input-select code |
| div2_o | output | 1 | Divide-by-two enable for the input clock |
| idx_o | output | 2 | Parameter-table index |

## Verification
The bench places the reference period exactly on and one cycle above every threshold, with and without the pre-divider. A non-strict comparison or a wrong bin order would therefore return the neighbouring class. Narrow counter widths force the counter to wrap several times before the window opens. A difference that is not taken modulo the counter width, or that is taken at the wrong width, would misclassify those periods. The bench counts the reference edges between start and done, which exposes an off-by-one in the lead-in or window tick counts. It also sends a second start with the opposite pre-divider flag in the middle of a measurement; a block that accepts it returns a doubled class.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [2:0] {
    FC_12M  = 3'd0,
    FC_13M  = 3'd1,
    FC_19M2 = 3'd2,
    FC_24M  = 3'd3,
    FC_26M  = 3'd4,
    FC_38M4 = 3'd5
  } freq_cls_e;

  typedef enum logic [1:0] {W_IDLE, W_LEAD, W_MEAS} win_st_e;

  localparam int unsigned NUM_BINS = 5;

  function automatic logic [2:0] sel_of(freq_cls_e c);
    case (c)
      FC_38M4: sel_of = 3'd4;
      FC_26M:  sel_of = 3'd3;
      FC_19M2: sel_of = 3'd2;
      FC_13M:  sel_of = 3'd1;
      default: sel_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ofc_ref_sync.sv
module ofc_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~last_q;

  // R10
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ofc_window.sv
module ofc_window
  import ofc_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LEAD_TICKS = 20,
  parameter int unsigned WIN_TICKS  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             prediv_i,
  input  logic             tick_i,
  output logic             fin_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             prediv_o
);
  localparam int unsigned MAXT = (LEAD_TICKS > WIN_TICKS) ? LEAD_TICKS : WIN_TICKS;
  localparam int unsigned TC_W = $clog2(MAXT + 1);
  localparam logic [TC_W-1:0] LEAD_LAST = TC_W'(LEAD_TICKS - 1);
  localparam logic [TC_W-1:0] WIN_LAST  = TC_W'(WIN_TICKS - 1);

  win_st_e          st_q;
  logic [CNT_W-1:0] fcnt_q, start_q, elapsed_q;
  logic [TC_W-1:0]  tcnt_q;
  logic             pdiv_q, fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= W_IDLE;
      fcnt_q    <= '0;
      start_q   <= '0;
      elapsed_q <= '0;
      tcnt_q    <= '0;
      pdiv_q    <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st_q)
        W_IDLE: if (start_i) begin
          fcnt_q <= '0;
          tcnt_q <= '0;
          pdiv_q <= prediv_i;
          st_q   <= W_LEAD;
        end
        W_LEAD: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (tick_i) begin
            if (tcnt_q == LEAD_LAST) begin
              start_q <= fcnt_q;
              tcnt_q  <= '0;
              st_q    <= W_MEAS;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        W_MEAS: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (tick_i) begin
            if (tcnt_q == WIN_LAST) begin
              elapsed_q <= fcnt_q - start_q;  // modulo 2^CNT_W
              fin_q     <= 1'b1;
              st_q      <= W_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign fin_o     = fin_q;
  assign elapsed_o = elapsed_q;
  assign prediv_o  = pdiv_q;

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != W_IDLE && start_i) |=> $stable(pdiv_q));
  // R2
  lead_to_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_LEAD && tick_i && tcnt_q == LEAD_LAST) |=> (st_q == W_MEAS && tcnt_q == '0));
  // R2
  fin_from_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> st_q == W_IDLE);
endmodule

// File: rtl/ofc_classify.sv
module ofc_classify
  import ofc_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TH_13M  = 7600,
  parameter int unsigned TH_19M2 = 9000,
  parameter int unsigned TH_24M  = 13000,
  parameter int unsigned TH_26M  = 15200,
  parameter int unsigned TH_38M4 = 19000
) (
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic             prediv_i,
  output freq_cls_e        cls_o,
  output logic [2:0]       sel_o,
  output logic             div2_o,
  output logic [1:0]       idx_o
);
  localparam int unsigned SC_W = CNT_W + 1;
  localparam logic [63:0] TH_V [NUM_BINS] = '{64'(TH_13M), 64'(TH_19M2), 64'(TH_24M),
                                             64'(TH_26M), 64'(TH_38M4)};
  localparam freq_cls_e CLS_V [NUM_BINS] = '{FC_13M, FC_19M2, FC_24M, FC_26M, FC_38M4};

  logic [SC_W-1:0]     scaled;
  logic [63:0]         scaled64;
  logic [NUM_BINS-1:0] above;

  assign scaled   = prediv_i ? {elapsed_i, 1'b0} : {1'b0, elapsed_i};
  assign scaled64 = 64'(scaled);

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    assign above[k] = scaled64 > TH_V[k];
  end

  // ascending scan: the highest bin passed wins
  always_comb begin
    cls_o = FC_12M;
    for (int k = 0; k < NUM_BINS; k++) begin
      if (above[k]) cls_o = CLS_V[k];
    end
  end

  assign sel_o  = sel_of(cls_o);
  assign div2_o = sel_o > 3'd2;
  assign idx_o  = div2_o ? 2'(sel_o >> 1) : 2'(sel_o);
endmodule

// File: rtl/osc_freq_classifier.sv
module osc_freq_classifier
  import ofc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_TICKS  = 20,
  parameter int unsigned WIN_TICKS   = 20,
  parameter int unsigned TH_13M      = 7600,
  parameter int unsigned TH_19M2     = 9000,
  parameter int unsigned TH_24M      = 13000,
  parameter int unsigned TH_26M      = 15200,
  parameter int unsigned TH_38M4     = 19000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic       start_i,
  input  logic       prediv_i,
  output logic       done_o,
  output logic [2:0] class_o,
  output logic [2:0] sel_o,
  output logic       div2_o,
  output logic [1:0] idx_o
);
  logic             tick, fin, pdiv;
  logic [CNT_W-1:0] elapsed;
  freq_cls_e        cls_d;
  logic [2:0]       sel_d;
  logic             div2_d;
  logic [1:0]       idx_d;

  ofc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ref_i, .tick_o(tick)
  );

  ofc_window #(.CNT_W(CNT_W), .LEAD_TICKS(LEAD_TICKS), .WIN_TICKS(WIN_TICKS)) u_win (
    .clk_i, .rst_ni, .start_i, .prediv_i, .tick_i(tick),
    .fin_o(fin), .elapsed_o(elapsed), .prediv_o(pdiv)
  );

  ofc_classify #(.CNT_W(CNT_W), .TH_13M(TH_13M), .TH_19M2(TH_19M2), .TH_24M(TH_24M),
                 .TH_26M(TH_26M), .TH_38M4(TH_38M4)) u_cls (
    .elapsed_i(elapsed), .prediv_i(pdiv),
    .cls_o(cls_d), .sel_o(sel_d), .div2_o(div2_d), .idx_o(idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      class_o <= FC_12M;
      sel_o   <= '0;
      div2_o  <= 1'b0;
      idx_o   <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        class_o <= cls_d;
        sel_o   <= sel_d;
        div2_o  <= div2_d;
        idx_o   <= idx_d;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(class_o) && $stable(sel_o) && $stable(div2_o) && $stable(idx_o)));
  // R7
  div2_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div2_o == (sel_o > 3'd2));
  // R6
  no_code_24m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == FC_24M) |-> (sel_o == 3'd0));
endmodule

// File: tb/osc_freq_classifier_bench.sv
module osc_freq_classifier_bench;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned LEAD  = 3;
  localparam int unsigned WIN   = 1;
  localparam int unsigned T13 = 76, T19 = 90, T24 = 130, T26 = 152, T38 = 190;

  logic clk = 1'b0, rst_n = 1'b0, ref_s = 1'b0, start = 1'b0, pdiv = 1'b0;
  logic done;
  logic [2:0] cls, sel;
  logic div2;
  logic [1:0] idx;

  int checks = 0, errors = 0, per = 40, ref_edges = 0, cyc = 0;

  always #2.5 clk = ~clk;

  osc_freq_classifier #(.CNT_W(CNT_W), .LEAD_TICKS(LEAD), .WIN_TICKS(WIN),
    .TH_13M(T13), .TH_19M2(T19), .TH_24M(T24), .TH_26M(T26), .TH_38M4(T38)) u_osc_freq_classifier (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .start_i(start), .prediv_i(pdiv),
    .done_o(done), .class_o(cls), .sel_o(sel), .div2_o(div2), .idx_o(idx)
  );

  initial begin
    forever begin
      @(negedge clk); ref_s = 1'b1;
      repeat (per / 2 - 1) @(negedge clk);
      @(negedge clk); ref_s = 1'b0;
      repeat (per - per / 2 - 1) @(negedge clk);
    end
  end

  always @(posedge ref_s) ref_edges++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cls(input int s);
    if (s > T38) return 5;
    if (s > T26) return 4;
    if (s > T24) return 3;
    if (s > T19) return 2;
    if (s > T13) return 1;
    return 0;
  endfunction

  function automatic int exp_sel(input int c);
    case (c)
      5: return 4;
      4: return 3;
      2: return 2;
      1: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(input int t, input bit pd, input bit busy_restart);
    int e0, sc, c, s, hold_c;
    bit ok;
    per = t;
    @(posedge ref_s); @(posedge ref_s);
    repeat (5) @(negedge clk);
    e0 = ref_edges;
    pdiv = pd; start = 1'b1;
    @(negedge clk); start = 1'b0; pdiv = 1'b0;
    if (busy_restart) begin
      repeat (t / 2) @(negedge clk);
      pdiv = ~pd; start = 1'b1;   // R9: must be ignored
      @(negedge clk); start = 1'b0; pdiv = 1'b0;
    end
    wait_done(ok);
    chk("R2 done seen", int'(ok), 1);
    if (!ok) return;
    chk("R2 ref edges start->done", ref_edges - e0, LEAD + WIN);
    sc = ((WIN * t) % (1 << CNT_W)) * (pd ? 2 : 1);   // R3 R4
    c = exp_cls(sc);
    s = exp_sel(c);
    chk(busy_restart ? "R9 class" : "R5 R4 R3 R10 class", int'(cls), c);
    chk("R6 sel", int'(sel), s);
    chk("R7 div2", int'(div2), (s > 2) ? 1 : 0);
    chk("R7 idx", int'(idx), (s > 2) ? (s >> 1) : s);
    hold_c = int'(cls);
    @(negedge clk);
    chk("R8 done width", int'(done), 0);
    repeat (20) @(negedge clk);
    chk("R8 class hold", int'(cls), hold_c);
    chk("R8 no extra done", int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int th[5];
    th = '{T13, T19, T24, T26, T38};
    repeat (4) @(negedge clk);
    // R1
    chk("R1 done", int'(done), 0);
    chk("R1 class", int'(cls), 0);
    chk("R1 sel", int'(sel), 0);
    chk("R1 div2", int'(div2), 0);
    chk("R1 idx", int'(idx), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no done after reset", int'(done), 0);
    // R5 boundaries, strict compare, both pre-divider settings
    foreach (th[k]) begin
      measure(th[k], 1'b0, 1'b0);
      measure(th[k] + 1, 1'b0, 1'b0);
      measure(th[k] / 2, 1'b1, 1'b0);
      measure(th[k] / 2 + 1, 1'b1, 1'b0);
    end
    // R10 R3 sweep; lead-in of 3 periods wraps the 8-bit counter for large t
    for (int t = 20; t <= 250; t += 11) begin
      measure(t, 1'b0, 1'b0);
      if (t <= 125) measure(t, 1'b1, 1'b0);
    end
    // R9 restart while busy with the opposite pre-divider flag
    measure(100, 1'b0, 1'b1);
    measure(60, 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule